// File: doc/BRIEF.md
# LCD Sync and Byte-Serial Pixel Generator

This block drives a parallel RGB LCD panel over an 8-bit data bus. It produces active-low horizontal and vertical sync strobes and a data-enable flag. During the active window of each visible line it streams one colour byte per clock, so every pixel takes three clocks. All timing is counted in LCD clock ticks and fixed by parameters. The defaults give a 320x240 panel with a 408-pixel line period and one blanking line at the start of each frame.

Pixel data comes in as 16-bit words on a valid/ready stream, normally fed by a fetch engine. The block unpacks each word into two bytes and sends the low byte first. If no word is ready when a byte is due, the block sends zero and sets a sticky underflow flag.

Top module: `lcd_scan_gen`

## Requirements
- R1: While reset is held or `en` is low, `hs_n` and `vs_n` are 1, and `de`, `pix_byte` and `in_ready` are 0. Reset also clears `underflow` to 0. Lowering `en` empties the unpacker.
- R2: After `en` is first sampled high, `vs_n` goes low in the very next cycle. `hs_n` goes low one cycle after that, so the vertical strobe leads the horizontal strobe by one clock.
- R3: `hs_n` is low for the first H_SYNC_CLK clocks of every line period. A line period is H_TOT_PIX*BYTES_PER_PIX clocks.
- R4: `vs_n` is low for V_SYNC_LINES line periods at the start of every frame. A frame is (V_BLANK_LINES+V_VIS_LINES) line periods long.
- R5: `de` is high from clock H_START_CLK of a line for H_ACT_PIX*BYTES_PER_PIX consecutive clocks, and only on visible lines. The first V_BLANK_LINES lines of each frame have no active clocks.
- R6: Each 16-bit word goes out as two bytes on consecutive active clocks. Bits [7:0] go first, then bits [15:8]. `in_ready` is high only on an active clock when no byte of the previous word is still held.
- R7: On an active clock where `in_ready` is high and `in_valid` is low, `pix_byte` is 0 and `underflow` becomes 1 from the next cycle. `underflow` then stays 1 until reset, even across disable.
- R8: Whenever `de` is low, `pix_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low stops and clears the timing |
| in_data | input | 16 | Pixel word, low byte sent first |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Word taken at this clock edge if valid |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active data clock |
| pix_byte | output | 8 | Colour byte |
| underflow | output | 1 | Sticky: a byte was due with no word available |

## Verification
Every output is decoded from registers, with no extra output stage. `vs_n` therefore changes in the first cycle after the edge that samples `en`, and `hs_n`, `de` and the line position follow one cycle later. `pix_byte` and `in_ready` are valid in the same cycle as `de`, while `underflow` shows the cycle after the starved byte. The bench keeps a cycle index that starts at the edge where `en` is taken. From that index it computes the expected line position and the expected byte stream, and it samples every output at the falling clock edge of each cycle.

// File: rtl/lcd_scan_pkg.sv
// Shared types for the LCD scan generator.
package lcd_scan_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef enum logic {UNP_EMPTY, UNP_HOLD} unp_state_e;
endpackage

// File: rtl/lcd_vtimer.sv
// Frame timer: counts clocks within a frame and decodes the vertical strobe.
// Assumes FRAME_CLK > VSYNC_CLK > 0. Starts counting in the cycle after en is sampled.
module lcd_vtimer #(
    parameter int FRAME_CLK = 294984,
    parameter int VSYNC_CLK = 3672
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic v_on,
    output logic vs_act
);
    localparam int VW = $clog2(FRAME_CLK);
    localparam logic [VW-1:0] LAST = VW'(FRAME_CLK - 1);
    localparam logic [VW-1:0] VS_END = VW'(VSYNC_CLK);

    logic [VW-1:0] v_cnt;

    // Run flag and frame clock counter with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            v_on  <= 1'b0;
            v_cnt <= '0;
        end else begin
            v_on <= 1'b1;
            if (v_on) v_cnt <= (v_cnt == LAST) ? '0 : v_cnt + 1'b1;
        end
    end

    // Vertical strobe while inside the first sync lines.
    always_comb vs_act = v_on && (v_cnt < VS_END);
endmodule

// File: rtl/lcd_htimer.sv
// Line timer: starts one clock after the frame timer, counts clocks in a line and
// lines in a frame, and decodes the horizontal strobe and the active window.
// Assumes H_START_CLK + H_ACT_CLK <= H_TOT_CLK and H_SYNC_CLK < H_TOT_CLK.
module lcd_htimer #(
    parameter int H_TOT_CLK  = 1224,
    parameter int H_SYNC_CLK = 90,
    parameter int H_START    = 204,
    parameter int H_ACT_CLK  = 960,
    parameter int V_BLANK    = 1,
    parameter int V_LINES    = 241
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic v_on,
    output logic h_on,
    output logic hs_act,
    output logic de_win
);
    localparam int HW = $clog2(H_TOT_CLK);
    localparam int LW = (V_LINES > 1) ? $clog2(V_LINES) : 1;
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOT_CLK - 1);
    localparam logic [HW-1:0] HS_END   = HW'(H_SYNC_CLK);
    localparam logic [HW-1:0] ACT_LO   = HW'(H_START);
    localparam logic [HW-1:0] ACT_HI   = HW'(H_START + H_ACT_CLK - 1);
    localparam logic [LW-1:0] L_LAST   = LW'(V_LINES - 1);

    logic [HW-1:0] h_cnt;
    logic [LW-1:0] line;
    logic          vis_line;

    // Line clock and line counters, started one clock behind the frame timer.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            h_on  <= 1'b0;
            h_cnt <= '0;
            line  <= '0;
        end else begin
            h_on <= v_on;
            if (h_on) begin
                if (h_cnt == H_LAST) begin
                    h_cnt <= '0;
                    line  <= (line == L_LAST) ? '0 : line + 1'b1;
                end else begin
                    h_cnt <= h_cnt + 1'b1;
                end
            end
        end
    end

    // Visible-line decode; no compare needed without blanking lines.
    generate
        if (V_BLANK == 0) begin : g_noblank
            assign vis_line = 1'b1;
        end else begin : g_blank
            assign vis_line = (line >= LW'(V_BLANK));
        end
    endgenerate

    // Strobe and active window decode.
    always_comb begin
        hs_act = h_on && (h_cnt < HS_END);
        de_win = h_on && vis_line && (h_cnt >= ACT_LO) && (h_cnt <= ACT_HI);
    end
endmodule

// File: rtl/lcd_byte_unpack.sv
// Word-to-byte unpacker: on each due clock emits the held high byte, or else takes
// a new word and emits its low byte, or else emits zero and flags underflow.
module lcd_byte_unpack
    import lcd_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  due,
    input  word_t in_data,
    input  logic  in_valid,
    output logic  in_ready,
    output byte_t byte_out,
    output logic  underflow
);
    unp_state_e state;
    byte_t      hi_byte;

    // Ready and output byte selection.
    always_comb begin
        in_ready = due && (state == UNP_EMPTY);
        if (!due)                   byte_out = '0;
        else if (state == UNP_HOLD) byte_out = hi_byte;
        else if (in_valid)          byte_out = in_data[BYTE_W-1:0];
        else                        byte_out = '0;
    end

    // Holding register, state and sticky underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= UNP_EMPTY;
            hi_byte   <= '0;
            underflow <= 1'b0;
        end else if (!en) begin
            state <= UNP_EMPTY;
        end else if (due) begin
            if (state == UNP_HOLD) begin
                state <= UNP_EMPTY;
            end else if (in_valid) begin
                hi_byte <= in_data[WORD_W-1:BYTE_W];
                state   <= UNP_HOLD;
            end else begin
                underflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcd_scan_gen.sv
// LCD sync and byte-serial pixel generator top. Fixed timing by parameters; all
// outputs decode registered state. Vertical timing starts one clock ahead.
module lcd_scan_gen #(
    parameter int H_ACT_PIX     = 320,
    parameter int H_TOT_PIX     = 408,
    parameter int BYTES_PER_PIX = 3,
    parameter int H_SYNC_CLK    = 90,
    parameter int H_START_CLK   = 204,
    parameter int V_BLANK_LINES = 1,
    parameter int V_VIS_LINES   = 240,
    parameter int V_SYNC_LINES  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [15:0] in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic        hs_n,
    output logic        vs_n,
    output logic        de,
    output logic [7:0]  pix_byte,
    output logic        underflow
);
    localparam int H_ACT_CLK = H_ACT_PIX * BYTES_PER_PIX;
    localparam int H_TOT_CLK = H_TOT_PIX * BYTES_PER_PIX;
    localparam int V_LINES   = V_BLANK_LINES + V_VIS_LINES;
    localparam int FRAME_CLK = V_LINES * H_TOT_CLK;
    localparam int VSYNC_CLK = V_SYNC_LINES * H_TOT_CLK;

    logic v_on, vs_act, h_on, hs_act, de_win;

    lcd_vtimer #(.FRAME_CLK(FRAME_CLK), .VSYNC_CLK(VSYNC_CLK)) u_vt (
        .clk(clk), .rst_n(rst_n), .en(en), .v_on(v_on), .vs_act(vs_act)
    );

    lcd_htimer #(
        .H_TOT_CLK(H_TOT_CLK), .H_SYNC_CLK(H_SYNC_CLK), .H_START(H_START_CLK),
        .H_ACT_CLK(H_ACT_CLK), .V_BLANK(V_BLANK_LINES), .V_LINES(V_LINES)
    ) u_ht (
        .clk(clk), .rst_n(rst_n), .en(en), .v_on(v_on),
        .h_on(h_on), .hs_act(hs_act), .de_win(de_win)
    );

    lcd_byte_unpack u_unp (
        .clk(clk), .rst_n(rst_n), .en(en), .due(de_win),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .byte_out(pix_byte), .underflow(underflow)
    );

    // Active-low strobes and data enable.
    always_comb begin
        hs_n = ~hs_act;
        vs_n = ~vs_act;
        de   = de_win;
    end
endmodule

// File: rtl/lcd_scan_chk.sv
// Property checker for lcd_scan_gen, attached by bind below.
module lcd_scan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       in_valid,
    input logic       in_ready,
    input logic       hs_n,
    input logic       vs_n,
    input logic       de,
    input logic [7:0] pix_byte,
    input logic       underflow,
    input logic       v_on,
    input logic       h_on
);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hs_n && vs_n && !de && !in_ready));
    p_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_on) |-> $past(v_on));
    p_hs_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_on) |-> (!vs_n && hs_n));
    p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> de);
    p_starve_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |-> (pix_byte == 8'd0) ##1 underflow);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix_byte == 8'd0));
endmodule

bind lcd_scan_gen lcd_scan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_ready(in_ready),
    .hs_n(hs_n), .vs_n(vs_n), .de(de), .pix_byte(pix_byte), .underflow(underflow),
    .v_on(v_on), .h_on(h_on)
);

// File: tb/test_lcd_scan_gen.sv
`timescale 1ns/1ps
module test_lcd_scan_gen;
    localparam int ACTP = 2, TOTP = 6, BPP = 3, HSYNC = 4, HSTART = 8;
    localparam int VBLANK = 1, VVIS = 3, VSYNCL = 2;
    localparam int HT = TOTP * BPP, HACT = ACTP * BPP, LINES = VBLANK + VVIS;
    localparam int FRAME = LINES * HT, VSC = VSYNCL * HT;

    // t, hs_n, vs_n, de
    localparam int NTAB = 12;
    localparam int TAB [NTAB][4] = '{
        '{0,1,0,0}, '{1,0,0,0}, '{4,0,0,0}, '{5,1,0,0}, '{9,1,0,0}, '{27,1,0,1},
        '{32,1,0,1}, '{33,1,0,0}, '{36,1,1,0}, '{71,1,1,0}, '{72,1,0,0}, '{73,0,0,0}};

    logic clk = 0, rst_n = 0, en = 0, in_valid = 0;
    logic [15:0] in_data = 16'h0;
    logic in_ready, hs_n, vs_n, de, underflow;
    logic [7:0] pix_byte;

    int checks = 0, failures = 0;
    int t = 0, wcnt = 0;
    bit running = 0, m_hold = 0, m_uf = 0;
    logic [7:0] m_hi = 0;
    logic last_hs, last_vs, last_de;

    always #2 clk = ~clk;

    lcd_scan_gen #(.H_ACT_PIX(ACTP), .H_TOT_PIX(TOTP), .BYTES_PER_PIX(BPP),
        .H_SYNC_CLK(HSYNC), .H_START_CLK(HSTART), .V_BLANK_LINES(VBLANK),
        .V_VIS_LINES(VVIS), .V_SYNC_LINES(VSYNCL)) i_lcd_scan_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .hs_n(hs_n), .vs_n(vs_n), .de(de),
        .pix_byte(pix_byte), .underflow(underflow));

    function automatic logic [15:0] wval(int n);
        return {~n[7:0], n[7:0] ^ 8'h5A};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
        end
    endtask

    // One cycle: sample at falling edge against the model, then advance.
    task automatic step();
        bit e_hs, e_vs, e_de, e_rdy, acc;
        logic [7:0] e_b;
        int h, ln;
        @(negedge clk);
        e_hs = 1; e_vs = 1; e_de = 0; e_rdy = 0; e_b = 0;
        if (running) begin
            e_vs = !((t % FRAME) < VSC);
            if (t >= 1) begin
                h = (t - 1) % HT;
                ln = ((t - 1) / HT) % LINES;
                e_hs = !(h < HSYNC);
                e_de = (ln >= VBLANK) && (h >= HSTART) && (h < HSTART + HACT);
            end
            if (e_de) begin
                if (m_hold) e_b = m_hi;
                else begin
                    e_rdy = 1;
                    e_b = in_valid ? in_data[7:0] : 8'h00;
                end
            end
        end
        check(running ? (t <= 1 ? "R2" : "R3") : "R1", 32'(hs_n), 32'(e_hs));
        check(running ? (t <= 1 ? "R2" : "R4") : "R1", 32'(vs_n), 32'(e_vs));
        check(running ? "R5" : "R1", 32'(de), 32'(e_de));
        check(e_de ? ((e_rdy && !in_valid) ? "R7" : "R6") : "R8", 32'(pix_byte), 32'(e_b));
        check("R6", 32'(in_ready), 32'(e_rdy));
        check("R7", 32'(underflow), 32'(m_uf));
        last_hs = hs_n; last_vs = vs_n; last_de = de;
        acc = in_ready && in_valid;
        if (running && e_de) begin
            if (m_hold) m_hold = 0;
            else if (in_valid) begin m_hi = in_data[15:8]; m_hold = 1; end
            else m_uf = 1;
        end
        @(posedge clk); #1;
        if (acc) begin wcnt++; in_data = wval(wcnt); end
        if (running) t++;
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        in_data = wval(0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step(); step();                       // R1: idle after reset
        in_valid = 1;
        en = 1; step(); running = 1; t = 0;   // R2: enable taken at this edge
        for (int i = 0; i < NTAB; i++) begin  // table walk with model checks each cycle
            while (t <= TAB[i][0]) step();
            check("R3", 32'(last_hs), 32'(TAB[i][1]));
            check("R4", 32'(last_vs), 32'(TAB[i][2]));
            check("R5", 32'(last_de), 32'(TAB[i][3]));
        end
        while (t < 150) step();               // rest of two frames, steady stream
        in_valid = 0;                         // R7: starve through an active line
        while (t < 190) step();
        check("R7", 32'(underflow), 32'd1);
        in_valid = 1;
        while (t < 220) step();
        en = 0; step(); running = 0; m_hold = 0; // R1: disable, R7 flag kept
        repeat (5) step();
        check("R7", 32'(underflow), 32'd1);
        en = 1; step(); running = 1; t = 0;   // R2: lead again after re-enable
        while (t < 40) step();
        rst_n = 0; step(); running = 0; m_hold = 0; m_uf = 0; en = 0;
        rst_n = 1; step(); step();            // R1: reset clears underflow
        check("R1", 32'(underflow), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule